// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block sits on the read path of a byte-wide nonvolatile memory. While an internal program or erase job runs, it replaces the array byte returned to the host with a status byte. Once the job ends, the array byte passes straight through again.

The status byte carries two separate completion indicators:

- **Polling bit.** During a program job it holds the complement of the most significant bit of the byte being written. During an erase job it holds 0.
- **Toggle bit.** It changes value once per qualified host read and never on clock edges alone.

The job engines raise `busy` after the last write of their command sequence. For a byte program that is the fourth write; for either erase it is the sixth. The reporter takes the job kind and the programmed byte at the cycle where `busy` rises.

A host read is one rising edge of `rd_strobe` while both `ce_n` and `oe_n` are low. The byte for that read is fixed at that edge and held until the strobe drops. A read that overlaps the end of a job therefore returns either the whole status byte or plain array data, never a mix of both.

Top module: `op_status_reporter`

## Requirements
- R1: During a program job, bit 7 of every status byte is the inverse of bit 7 of `prog_byte` as sampled on the clock edge where `busy` was first seen high. Later changes to `prog_byte` do not affect it.
- R2: During an erase job (`op_erase` high when the job starts), bit 7 of every status byte is 0.
- R3: Bit 6 of the first status byte of each job is 0. Each later qualified read in the same job returns the opposite bit 6 value to the read before it.
- R4: A strobe rise with `ce_n` or `oe_n` high is not a read. It returns the array byte and does not advance the toggle bit.
- R5: Bits 5 to 0 of every status byte are 0.
- R6: Reads whose strobe rises after `busy` has been low for at least one clock edge return `array_byte` unchanged. The toggle bit no longer advances.
- R7: The byte chosen at a read's strobe rise is held unchanged while the strobe stays high, even if `busy` falls or `array_byte` changes.
- R8: During and after reset, with no read in progress, `rd_byte` equals `array_byte`.
- R9: The chosen byte appears on `rd_byte` from the first clock edge at which the strobe is seen high. From the edge after the strobe is seen low, `rd_byte` follows `array_byte` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy | input | 1 | High while a program or erase job runs |
| op_erase | input | 1 | Job kind at job start: 1 erase, 0 program |
| prog_byte | input | DW | Byte being programmed |
| rd_strobe | input | 1 | Read access strobe; rising edge starts a read |
| ce_n | input | 1 | Active-low chip enable, qualifies reads |
| oe_n | input | 1 | Active-low output enable, qualifies reads |
| array_byte | input | DW | Data from the memory array |
| rd_byte | output | DW | Byte returned to the host |

## Verification
The bench walks the host reads one at a time, because a wrong toggle state shows up on the next qualified read as a repeated bit 6 value. That read can come as soon as two clocks after the previous one.

A stale or missing job-start latch is caught on the first status read of a job. It shows as a wrong bit 7, or as a bit 6 that does not begin at 0.

A read-qualification fault shows as status on a gated read, or as a skipped toggle on the read after it. A capture fault shows as a status byte that changes, or that falls through to array data, while a read overlapping the end of a job is still held.

// File: rtl/op_status_reporter.sv
module op_status_reporter #(
  parameter int DW       = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          op_erase,
  input  logic [DW-1:0] prog_byte,
  input  logic          rd_strobe,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [DW-1:0] array_byte,
  output logic [DW-1:0] rd_byte
);

  logic          strobe_q;
  logic          busy_q;
  logic          poll_val;
  logic          tog;
  logic          cap_status;
  logic [DW-1:0] cap_byte;
  logic [DW-1:0] status_now;

  wire read_rise = rd_strobe & ~strobe_q & ~ce_n & ~oe_n;
  wire job_start = busy & ~busy_q;

  always_comb begin
    status_now           = '0;
    status_now[POLL_BIT] = poll_val;
    status_now[TOG_BIT]  = tog;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q   <= 1'b0;
      busy_q     <= 1'b0;
      poll_val   <= 1'b0;
      tog        <= 1'b0;
      cap_status <= 1'b0;
      cap_byte   <= '0;
    end else begin
      strobe_q <= rd_strobe;
      busy_q   <= busy;
      if (job_start) begin
        poll_val <= op_erase ? 1'b0 : ~prog_byte[POLL_BIT];
        tog      <= 1'b0;
      end else if (read_rise && busy_q) begin
        tog <= ~tog;
      end
      if (read_rise) begin
        cap_status <= busy_q;
        cap_byte   <= status_now;
      end else if (!rd_strobe) begin
        cap_status <= 1'b0;
      end
    end
  end

  assign rd_byte = cap_status ? cap_byte : array_byte;

endmodule

// File: rtl/op_status_reporter_chk.sv
module op_status_reporter_chk #(
  parameter int DW       = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          op_erase,
  input logic          prog_msb,
  input logic          rd_strobe,
  input logic [DW-1:0] array_byte,
  input logic [DW-1:0] rd_byte,
  input logic          cap_status
);

  localparam logic [DW-1:0] LOW_MASK = ~((DW'(1) << POLL_BIT) | (DW'(1) << TOG_BIT));

  logic busy_p, erase_lat, prog_lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_p    <= 1'b0;
      erase_lat <= 1'b0;
      prog_lat  <= 1'b0;
    end else begin
      busy_p <= busy;
      if (busy && !busy_p) begin
        erase_lat <= op_erase;
        prog_lat  <= prog_msb;
      end
    end
  end

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cap_status |-> ((rd_byte & LOW_MASK) == '0)); // R5

  AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_status && erase_lat) |-> (rd_byte[POLL_BIT] == 1'b0)); // R2

  AST_PROG_POLL_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_status && !erase_lat) |-> (rd_byte[POLL_BIT] == ~prog_lat)); // R1

  AST_HELD_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_status && $past(cap_status) && rd_strobe && $past(rd_strobe)) |-> $stable(rd_byte)); // R7

  AST_IDLE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> (rd_byte == array_byte)); // R9

  AST_STATUS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_status) |-> $past(busy, 2)); // R6

endmodule

bind op_status_reporter op_status_reporter_chk #(
  .DW(DW), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .op_erase(op_erase),
  .prog_msb(prog_byte[POLL_BIT]), .rd_strobe(rd_strobe),
  .array_byte(array_byte), .rd_byte(rd_byte), .cap_status(cap_status)
);

// File: tb/op_status_reporter_tb.sv
module op_status_reporter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busy = 1'b0;
  logic       op_erase = 1'b0;
  logic [7:0] prog_byte = 8'h00;
  logic       rd_strobe = 1'b0;
  logic       ce_n = 1'b1;
  logic       oe_n = 1'b1;
  logic [7:0] array_byte = 8'h5A;
  logic [7:0] rd_byte;
  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  op_status_reporter u_dut (
    .clk(clk), .rst_n(rst_n), .busy(busy), .op_erase(op_erase),
    .prog_byte(prog_byte), .rd_strobe(rd_strobe), .ce_n(ce_n), .oe_n(oe_n),
    .array_byte(array_byte), .rd_byte(rd_byte)
  );

  // {erase, programmed byte, number of status reads}
  localparam logic [12:0] VEC [6] = '{
    {1'b0, 8'h80, 4'd3},
    {1'b0, 8'h3C, 4'd4},
    {1'b1, 8'h00, 4'd5},
    {1'b1, 8'hFF, 4'd2},
    {1'b0, 8'hFF, 4'd1},
    {1'b0, 8'h7F, 4'd6}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic ce, input logic oe, output logic [7:0] v);
    @(negedge clk);
    ce_n = ce; oe_n = oe; rd_strobe = 1'b1;
    @(negedge clk);
    v = rd_byte;
    rd_strobe = 1'b0;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic start_op(input logic e, input logic [7:0] d);
    @(negedge clk);
    op_erase = e; prog_byte = d; busy = 1'b1;
    @(negedge clk);
  endtask

  task automatic end_op;
    @(negedge clk);
    busy = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] exp;
    repeat (3) @(negedge clk);
    check("R8 in reset", rd_byte, 8'h5A);
    rst_n = 1'b1;
    @(negedge clk);
    array_byte = 8'h33;
    #1 check("R8 after reset", rd_byte, 8'h33);
    do_read(1'b0, 1'b0, v);
    check("R6 idle read", v, 8'h33);

    // Table walk; an odd read count leaves the toggle at 1 so the next job checks the restart (R3)
    for (int k = 0; k < 6; k++) begin
      start_op(VEC[k][12], VEC[k][11:4]);
      prog_byte = ~VEC[k][11:4];
      for (int i = 0; i < int'(VEC[k][3:0]); i++) begin
        do_read(1'b0, 1'b0, v);
        exp = {(VEC[k][12] ? 1'b0 : ~VEC[k][11]), i[0], 6'b0};
        check(VEC[k][12] ? "R2 R3 R5 erase status" : "R1 R3 R5 program status", v, exp);
      end
      array_byte = 8'hA5 ^ 8'(k);
      end_op;
      do_read(1'b0, 1'b0, v);
      check("R6 after completion", v, 8'hA5 ^ 8'(k));
      do_read(1'b0, 1'b0, v);
      check("R6 second read after completion", v, 8'hA5 ^ 8'(k));
    end

    // Gated reads R4
    array_byte = 8'h96;
    start_op(1'b0, 8'h00);
    do_read(1'b0, 1'b0, v);
    check("R4 first qualified read", v, 8'h80);
    do_read(1'b1, 1'b0, v);
    check("R4 ce_n high read", v, 8'h96);
    do_read(1'b0, 1'b1, v);
    check("R4 oe_n high read", v, 8'h96);
    do_read(1'b0, 1'b0, v);
    check("R4 toggle not advanced", v, 8'hC0);

    // Read straddling completion R7 then R9
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; rd_strobe = 1'b1;
    @(negedge clk);
    check("R9 byte at first edge", rd_byte, 8'h80);
    busy = 1'b0;
    array_byte = 8'h69;
    repeat (2) @(negedge clk);
    check("R7 held across completion", rd_byte, 8'h80);
    rd_strobe = 1'b0;
    @(negedge clk);
    check("R9 passthrough after strobe low", rd_byte, 8'h69);
    ce_n = 1'b1; oe_n = 1'b1;
    do_read(1'b0, 1'b0, v);
    check("R6 read after straddle", v, 8'h69);

    // Program byte change after start R1
    start_op(1'b0, 8'h7E);
    prog_byte = 8'hFF;
    do_read(1'b0, 1'b0, v);
    check("R1 latched programmed byte", v, 8'h80);
    end_op;

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule